// File: doc/BRIEF.md
# Program Counter Tag Stripping Unit

This unit sits between the logic that chooses the next program counter value for a branch or exception and the program counter register of a 64-bit core that supports tagged pointers. Every candidate target comes with a load type, a destination privilege level and the top-byte-ignore enables of all levels. When the enable that applies is set, the unit decides that the top byte of the address is a tag. It then overwrites bits 63:56 with a fill value before the address reaches the program counter. Untagged values pass through unchanged.

The same rule applies to three kinds of load. A register-indirect branch uses its target address. Exception entry uses the vector table base, and the unit splices the vector offset into its low bits. Exception return uses the saved return address. The enables are taken from the level the core lands in. An illegal exception return leaves the core at its current level, so that level's enables are used. No tag bit ever reaches the program counter on any path. The cleaned value is registered and presented one cycle after the input strobe, together with a valid output.

Top module: `pctag_strip`

## Requirements
- R1: After reset, `pc_o` is zero and `pc_valid_o` is low.
- R2: A cycle with `valid_i` high produces its result on `pc_o` and raises `pc_valid_o` at the next rising clock edge. After a cycle with `valid_i` low, `pc_valid_o` is low and `pc_o` keeps its previous value, whatever the other inputs are.
- R3: For effective levels 0 and 1, address bit 55 selects the enable. A 0 selects `tbi_en_i[0]` and a 1 selects `tbi_en_i[1]`. When the selected enable is 1, bits 63:56 of `pc_o` are all copies of bit 55.
- R4: For effective level 2 the enable is `tbi_en_i[2]`, and for level 3 it is `tbi_en_i[3]`. When that enable is 1, bits 63:56 of `pc_o` are zero, whatever bit 55 is.
- R5: When the applicable enable is 0, bits 63:56 of `pc_o` equal bits 63:56 of `addr_i`.
- R6: For branch and return loads, bits 55:0 of `pc_o` equal bits 55:0 of `addr_i`.
- R7: For exception entry, `pc_o` is the vector base `addr_i` cleaned by R3 to R5, with bits 10:0 replaced by `voff_i`.
- R8: The effective level is `dst_lvl_i`. The one exception is a return with `ret_illegal_i` high, which uses `src_lvl_i`. `ret_illegal_i` has no effect on branch or entry loads.
- R9: `kind_i` encodes the load type: 0 is a register branch, 1 is exception entry, 2 is exception return. Code 3 behaves exactly like a register branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | A new program counter value is presented |
| kind_i | input | 2 | Load type (0 branch, 1 entry, 2 return, 3 as branch) |
| addr_i | input | 64 | Branch target, vector base or return address |
| voff_i | input | 11 | Vector offset used on exception entry |
| dst_lvl_i | input | 2 | Privilege level the load lands in |
| src_lvl_i | input | 2 | Privilege level the load starts from |
| ret_illegal_i | input | 1 | The exception return is illegal (core stays at the source level) |
| tbi_en_i | input | 4 | Top-byte-ignore enables: [0] lower levels low half, [1] lower levels high half, [2] level 2, [3] level 3 |
| pc_o | output | 64 | Cleaned program counter value |
| pc_valid_o | output | 1 | `pc_o` was updated at the last edge |

## Verification
Every cleaned value is due exactly one rising edge after the cycle that presents it. The bench drives inputs on the falling edge and checks `pc_o` and `pc_valid_o` on the next falling edge, half a period after the edge that loads them. After an idle cycle with scrambled inputs, the bench checks on the following falling edge that the held value has not moved. Random transactions cover every level, enable pattern, bit 55 value and load type, and directed cases cover illegal returns, code 3 and the entry offset splice.

// File: rtl/pctag_pkg.sv
package pctag_pkg;

    localparam int LVL_W   = 2;
    localparam int NUM_LVL = 1 << LVL_W;

    typedef enum logic [1:0] {
        LD_BRANCH = 2'd0,
        LD_ENTRY  = 2'd1,
        LD_RETURN = 2'd2,
        LD_ALIAS  = 2'd3
    } load_kind_e;

    typedef logic [LVL_W-1:0] lvl_t;

endpackage

// File: rtl/pctag_level_sel.sv
module pctag_level_sel
    import pctag_pkg::*;
(
    input  load_kind_e kind,
    input  lvl_t       dst_lvl,
    input  lvl_t       src_lvl,
    input  logic       ret_illegal,
    output lvl_t       lvl_eff,
    output logic       upper
);

    logic stay_put;

    always_comb begin
        // An illegal return keeps the core where it started.
        stay_put = (kind == LD_RETURN) && ret_illegal;
        lvl_eff  = stay_put ? src_lvl : dst_lvl;
        upper    = lvl_eff[LVL_W-1];
    end

endmodule

// File: rtl/pctag_form.sv
module pctag_form
    import pctag_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int VOFF_W = 11
) (
    input  load_kind_e        kind,
    input  logic [ADDR_W-1:0] addr,
    input  logic [VOFF_W-1:0] voff,
    output logic [ADDR_W-1:0] raw
);

    always_comb begin
        unique case (kind)
            LD_ENTRY: raw = {addr[ADDR_W-1:VOFF_W], voff};
            default:  raw = addr;
        endcase
    end

endmodule

// File: rtl/pctag_fill.sv
module pctag_fill
    import pctag_pkg::*;
#(
    parameter int ADDR_W  = 64,
    parameter int TAG_LSB = 56,
    parameter int SEL_BIT = 55
) (
    input  logic [ADDR_W-1:0]  raw,
    input  lvl_t               lvl_eff,
    input  logic               upper,
    input  logic [NUM_LVL-1:0] tbi_en,
    output logic [ADDR_W-1:0]  clean
);

    lvl_t en_idx;
    logic apply;
    logic fill_bit;

    always_comb begin
        en_idx   = upper ? lvl_eff : lvl_t'(raw[SEL_BIT]);
        apply    = tbi_en[en_idx];
        fill_bit = upper ? 1'b0 : raw[SEL_BIT];
    end

    assign clean[TAG_LSB-1:0] = raw[TAG_LSB-1:0];

    for (genvar g = TAG_LSB; g < ADDR_W; g++) begin : g_tag
        assign clean[g] = apply ? fill_bit : raw[g];
    end

endmodule

// File: rtl/pctag_strip.sv
module pctag_strip
    import pctag_pkg::*;
#(
    parameter int ADDR_W  = 64,
    parameter int TAG_LSB = 56,
    parameter int SEL_BIT = 55,
    parameter int VOFF_W  = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                valid_i,
    input  logic [1:0]          kind_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [VOFF_W-1:0]   voff_i,
    input  logic [LVL_W-1:0]    dst_lvl_i,
    input  logic [LVL_W-1:0]    src_lvl_i,
    input  logic                ret_illegal_i,
    input  logic [NUM_LVL-1:0]  tbi_en_i,
    output logic [ADDR_W-1:0]   pc_o,
    output logic                pc_valid_o
);

    localparam int TAG_W = ADDR_W - TAG_LSB;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic              vld;
    } state_t;

    load_kind_e        kind;
    lvl_t              lvl_eff;
    logic              upper;
    logic [ADDR_W-1:0] raw;
    logic [ADDR_W-1:0] clean;
    state_t            st_d, st_q;

    assign kind = load_kind_e'(kind_i);

    pctag_level_sel u_lvl (
        .kind        (kind),
        .dst_lvl     (dst_lvl_i),
        .src_lvl     (src_lvl_i),
        .ret_illegal (ret_illegal_i),
        .lvl_eff     (lvl_eff),
        .upper       (upper)
    );

    pctag_form #(.ADDR_W(ADDR_W), .VOFF_W(VOFF_W)) u_form (
        .kind (kind),
        .addr (addr_i),
        .voff (voff_i),
        .raw  (raw)
    );

    pctag_fill #(.ADDR_W(ADDR_W), .TAG_LSB(TAG_LSB), .SEL_BIT(SEL_BIT)) u_fill (
        .raw     (raw),
        .lvl_eff (lvl_eff),
        .upper   (upper),
        .tbi_en  (tbi_en_i),
        .clean   (clean)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = valid_i;
        if (valid_i) begin
            st_d.pc = clean;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_o       = st_q.pc;
    assign pc_valid_o = st_q.vld;

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> pc_valid_o);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> (!pc_valid_o && $stable(pc_o)));

    // R4
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && lvl_eff[LVL_W-1] && tbi_en_i[lvl_eff])
        |=> (pc_o[ADDR_W-1:TAG_LSB] == '0));

    // R3
    lower_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !lvl_eff[LVL_W-1] && tbi_en_i[addr_i[SEL_BIT]])
        |=> (pc_o[ADDR_W-1:TAG_LSB] == {TAG_W{$past(addr_i[SEL_BIT])}}));

    // R6
    low_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && kind_i != 2'd1)
        |=> (pc_o[TAG_LSB-1:0] == $past(addr_i[TAG_LSB-1:0])));

    // R7
    entry_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && kind_i == 2'd1)
        |=> (pc_o[VOFF_W-1:0] == $past(voff_i)));

    // R8
    illegal_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && kind_i == 2'd2 && ret_illegal_i && src_lvl_i[LVL_W-1]
         && tbi_en_i[src_lvl_i])
        |=> (pc_o[ADDR_W-1:TAG_LSB] == '0));

endmodule

// File: tb/tb_pctag_strip.sv
module tb_pctag_strip;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [1:0]  kind_i = '0;
    logic [63:0] addr_i = '0;
    logic [10:0] voff_i = '0;
    logic [1:0]  dst_lvl_i = '0;
    logic [1:0]  src_lvl_i = '0;
    logic        ret_illegal_i = 1'b0;
    logic [3:0]  tbi_en_i = '0;
    logic [63:0] pc_o;
    logic        pc_valid_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pctag_strip dut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .kind_i(kind_i),
        .addr_i(addr_i), .voff_i(voff_i), .dst_lvl_i(dst_lvl_i),
        .src_lvl_i(src_lvl_i), .ret_illegal_i(ret_illegal_i),
        .tbi_en_i(tbi_en_i), .pc_o(pc_o), .pc_valid_o(pc_valid_o)
    );

    function automatic logic [1:0] ref_lvl(logic [1:0] k, logic [1:0] d,
                                           logic [1:0] s, logic ill);
        return (k == 2'd2 && ill) ? s : d;
    endfunction

    function automatic logic [63:0] ref_pc(logic [1:0] k, logic [63:0] a,
            logic [10:0] vo, logic [1:0] d, logic [1:0] s, logic ill,
            logic [3:0] en);
        logic [1:0]  l;
        logic [63:0] r;
        logic        ap;
        l = ref_lvl(k, d, s, ill);
        r = (k == 2'd1) ? {a[63:11], vo} : a;
        if (l >= 2) ap = en[l];
        else        ap = a[55] ? en[1] : en[0];
        if (ap) r[63:56] = (l >= 2) ? 8'h00 : {8{a[55]}};
        return r;
    endfunction

    function automatic string ref_tag(logic [1:0] k, logic [63:0] a,
            logic [1:0] d, logic [1:0] s, logic ill, logic [3:0] en);
        logic [1:0] l;
        logic       ap;
        l = ref_lvl(k, d, s, ill);
        ap = (l >= 2) ? en[l] : (a[55] ? en[1] : en[0]);
        if (k == 2'd1)             return "R7";
        if (k == 2'd2 && ill)      return "R8";
        if (k == 2'd3)             return "R9";
        if (ap && l >= 2)          return "R4";
        if (ap)                    return "R3";
        return "R5";
    endfunction

    task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Drive one load on a falling edge, check it one falling edge later.
    task automatic load(logic [1:0] k, logic [63:0] a, logic [10:0] vo,
            logic [1:0] d, logic [1:0] s, logic ill, logic [3:0] en);
        logic [63:0] exp;
        @(negedge clk);
        valid_i = 1'b1; kind_i = k; addr_i = a; voff_i = vo;
        dst_lvl_i = d; src_lvl_i = s; ret_illegal_i = ill; tbi_en_i = en;
        exp = ref_pc(k, a, vo, d, s, ill, en);
        @(negedge clk);
        valid_i = 1'b0;
        check64(ref_tag(k, a, d, s, ill, en), pc_o, exp);
        check64("R2", {63'd0, pc_valid_o}, 64'd1);
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [63:0] held;
        logic [63:0] a;
        void'($urandom(32'd20240611));
        #(CLK_PERIOD * 2 + 2);
        // R1 reset state
        check64("R1", pc_o, 64'd0);
        check64("R1", {63'd0, pc_valid_o}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3 lower level, both halves, enabled
        load(2'd0, 64'h5A00_1234_5678_9ABC, 11'd0, 2'd1, 2'd0, 1'b0, 4'b0001);
        load(2'd0, 64'h5A80_1234_5678_9ABC, 11'd0, 2'd0, 2'd0, 1'b0, 4'b0010);
        // R5 wrong half enabled only
        load(2'd0, 64'h5A80_1234_5678_9ABC, 11'd0, 2'd0, 2'd0, 1'b0, 4'b0001);
        // R4 upper levels force zero with bit 55 set
        load(2'd2, 64'hFF80_0000_0000_1000, 11'd0, 2'd3, 2'd0, 1'b0, 4'b1000);
        load(2'd2, 64'hC3FF_FFFF_FFFF_F000, 11'd0, 2'd2, 2'd1, 1'b0, 4'b0100);
        // R8 destination enables used, not source
        load(2'd2, 64'hAB00_0000_0000_4000, 11'd0, 2'd0, 2'd3, 1'b0, 4'b1000);
        // R8 illegal return uses source level
        load(2'd2, 64'hAB80_0000_0000_4000, 11'd0, 2'd0, 2'd3, 1'b1, 4'b1000);
        // R8 illegal flag ignored on a branch
        load(2'd0, 64'hAB80_0000_0000_4000, 11'd0, 2'd0, 2'd3, 1'b1, 4'b0010);
        // R7 entry with offset splice
        load(2'd1, 64'h7700_0000_8000_07FF, 11'h280, 2'd1, 2'd0, 1'b0, 4'b0001);
        // R9 code 3 acts as a branch
        load(2'd3, 64'h1280_0000_0000_07FF, 11'h3FF, 2'd1, 2'd0, 1'b0, 4'b0010);

        // R6 low bits kept on return
        a = 64'h9955_4433_2211_00EE;
        load(2'd2, a, 11'h7FF, 2'd3, 2'd3, 1'b0, 4'b1111);
        check64("R6", {8'd0, pc_o[55:0]}, {8'd0, a[55:0]});

        // R2 idle cycle holds the value
        held = pc_o;
        @(negedge clk);
        valid_i = 1'b0; addr_i = 64'hDEAD_BEEF_0000_0000; kind_i = 2'd1;
        tbi_en_i = 4'b1111;
        @(negedge clk);
        check64("R2", pc_o, held);
        check64("R2", {63'd0, pc_valid_o}, 64'd0);

        for (int i = 0; i < 1500; i++) begin
            load(2'($urandom), rnd64(), 11'($urandom), 2'($urandom),
                 2'($urandom), 1'($urandom), 4'($urandom));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule